// File: doc/BRIEF.md
# Clock Frequency Ratio Monitor

This block measures how fast a monitored clock runs compared with a reference clock. A free-running timer in the reference domain marks out windows of exactly 2^FRAC_W reference cycles. A counter in the monitored domain counts monitored cycles between two consecutive window marks. That count crosses back to the reference domain and lands in a result register. Software reads the register as a read-only status field.

Because the window length is a power of two, the raw count is already the frequency ratio in unsigned fixed point. It has INT_W integer bits and FRAC_W fraction bits, which is a 16.16 value with the default parameters. One LSB therefore equals the reference frequency divided by 2^FRAC_W, which is about 1.526 kHz with a 100 MHz reference. A value of zero means the monitored clock is not running. The window mark reaches the monitored domain as a toggle through a synchronizer, and the count returns the same way, so no multi-bit value is ever sampled while it is changing.

Top module: `clk_ratio_monitor`

## Requirements
- R1: The result is the number of monitored clock cycles counted in one window of 2^FRAC_W reference cycles, read as an unsigned INT_W.FRAC_W ratio. With equal clock frequencies it equals 2^FRAC_W within one LSB.
- R2: While either reset is asserted, and after reset until the second window boundary has passed, the result reads 0.
- R3: The result scales with the monitored frequency. For monitored clocks slower or faster than the reference, it equals 2^FRAC_W × f_mon / f_ref within one LSB.
- R4: When the count exceeds the result width, the result saturates at all ones (2^(INT_W+FRAC_W) − 1) and does not wrap.
- R5: If no completed count reaches the reference domain for two window boundaries in a row, the result is forced to 0, and it stays 0 while the monitored clock is stopped.
- R6: After the monitored clock restarts, the result returns to the correct ratio within five windows. The first partial count after reset is discarded.
- R7: The result changes at most once per window and holds its value between updates.
- R8: A captured count stays stable in the monitored domain from one capture to the next. The reference domain loads it only after a synchronized toggle announces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference (register-interface) clock |
| ref_rst_n | input | 1 | Asynchronous active-low reset, reference domain |
| mon_clk | input | 1 | Monitored clock whose frequency is measured |
| mon_rst_n | input | 1 | Asynchronous active-low reset, monitored domain |
| ratio_o | output | INT_W+FRAC_W | Unsigned fixed-point ratio f_mon/f_ref; 0 when the monitored clock is idle |

## Verification
The hardest cases to reach are a monitored clock that stops completely and one that overruns the result width. The default window of 65536 reference cycles leaves no room for many measurements, and a 16-bit integer part cannot be overrun by any practical clock. The bench therefore builds the block with a 64-cycle window and a 2-bit integer part. Its monitored clock generator can change period on the fly or halt outright. That makes the stale-count timeout, saturation and recovery after a restart each reachable within a few hundred cycles.

// File: rtl/crm_pkg.sv
`timescale 1ns/1ps
package crm_pkg;
   // smallest window exponent that still leaves room for the handshake latency
   localparam int unsigned CRM_MIN_FRAC_W = 4;
   // fewest flops in a clock-domain synchronizer
   localparam int unsigned CRM_MIN_SYNC   = 2;
   // window boundaries without a fresh count before the result is cleared
   localparam int unsigned CRM_STALE_WINS = 2;
endpackage

// File: rtl/crm_sync_bit.sv
`timescale 1ns/1ps
module crm_sync_bit #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[i] <= 1'b0;
            else        pipe_q[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[i] <= 1'b0;
            else        pipe_q[i] <= pipe_q[i-1];
         end
      end
   end

   assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/crm_window_timer.sv
`timescale 1ns/1ps
module crm_window_timer #(
   parameter int unsigned FRAC_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic win_tick,
   output logic req_tgl
);
   logic [FRAC_W-1:0] tmr_q;

   assign win_tick = &tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q   <= '0;
         req_tgl <= 1'b0;
      end else begin
         tmr_q <= tmr_q + 1'b1;
         if (win_tick) req_tgl <= ~req_tgl;
      end
   end

   // R7
   req_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_tick |=> $stable(req_tgl));

   // R7
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_tick |=> !win_tick);
endmodule

// File: rtl/crm_mon_counter.sv
`timescale 1ns/1ps
module crm_mon_counter #(
   parameter int unsigned RES_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_s,
   output logic [RES_W-1:0] snap_q,
   output logic             ack_tgl
);
   localparam logic [RES_W-1:0] CNT_MAX = '1;

   logic             req_d;
   logic             capture;
   logic             primed_q;
   logic [RES_W-1:0] cnt_q;
   logic [RES_W-1:0] cnt_inc;

   assign capture = req_s ^ req_d;
   assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_d    <= 1'b0;
         primed_q <= 1'b0;
         cnt_q    <= '0;
         snap_q   <= '0;
         ack_tgl  <= 1'b0;
      end else begin
         req_d <= req_s;
         if (capture) begin
            cnt_q    <= '0;
            primed_q <= 1'b1;
            if (primed_q) begin
               snap_q  <= cnt_inc;
               ack_tgl <= ~ack_tgl;
            end
         end else begin
            cnt_q <= cnt_inc;
         end
      end
   end

   // R4
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX) && !capture |=> cnt_q == CNT_MAX);

   // R8
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(snap_q) && $stable(ack_tgl));

   // R2
   first_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !primed_q |=> $stable(ack_tgl));
endmodule

// File: rtl/crm_result_reg.sv
`timescale 1ns/1ps
module crm_result_reg #(
   parameter int unsigned RES_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_tick,
   input  logic             ack_s,
   input  logic [RES_W-1:0] snap,
   output logic [RES_W-1:0] ratio_q
);
   logic ack_d;
   logic ack_evt;
   logic stale_q;

   assign ack_evt = ack_s ^ ack_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_d   <= 1'b0;
         stale_q <= 1'b0;
         ratio_q <= '0;
      end else begin
         ack_d <= ack_s;
         if (ack_evt) begin
            ratio_q <= snap;
            stale_q <= 1'b0;
         end else if (win_tick) begin
            if (stale_q) ratio_q <= '0;
            stale_q <= 1'b1;
         end
      end
   end

   // R7
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_evt && !win_tick |=> $stable(ratio_q));

   // R5
   stale_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_tick && stale_q && !ack_evt |=> ratio_q == '0);

   // R8
   snap_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_evt |-> $stable(snap));
endmodule

// File: rtl/clk_ratio_monitor.sv
`timescale 1ns/1ps
module clk_ratio_monitor #(
   parameter int unsigned INT_W       = 16,
   parameter int unsigned FRAC_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                    ref_clk,
   input  logic                    ref_rst_n,
   input  logic                    mon_clk,
   input  logic                    mon_rst_n,
   output logic [INT_W+FRAC_W-1:0] ratio_o
);
   import crm_pkg::*;

   localparam int unsigned RES_W = INT_W + FRAC_W;

   initial begin
      frac_w_chk: assert (FRAC_W >= CRM_MIN_FRAC_W)
         else $error("FRAC_W too small for handshake latency");
      sync_chk: assert (SYNC_STAGES >= CRM_MIN_SYNC)
         else $error("SYNC_STAGES must be at least two");
      int_w_chk: assert (INT_W >= 1)
         else $error("INT_W must be at least one");
      stale_cfg_chk: assert (CRM_STALE_WINS == 2)
         else $error("stale logic is built for two windows");
   end

   logic             win_tick;
   logic             req_tgl;
   logic             req_s;
   logic             ack_tgl;
   logic             ack_s;
   logic [RES_W-1:0] snap;

   crm_window_timer #(.FRAC_W(FRAC_W)) u_timer (
      .clk      (ref_clk),
      .rst_n    (ref_rst_n),
      .win_tick (win_tick),
      .req_tgl  (req_tgl)
   );

   crm_sync_bit #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (mon_clk),
      .rst_n (mon_rst_n),
      .d     (req_tgl),
      .q     (req_s)
   );

   crm_mon_counter #(.RES_W(RES_W)) u_count (
      .clk     (mon_clk),
      .rst_n   (mon_rst_n),
      .req_s   (req_s),
      .snap_q  (snap),
      .ack_tgl (ack_tgl)
   );

   crm_sync_bit #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (ref_clk),
      .rst_n (ref_rst_n),
      .d     (ack_tgl),
      .q     (ack_s)
   );

   crm_result_reg #(.RES_W(RES_W)) u_result (
      .clk      (ref_clk),
      .rst_n    (ref_rst_n),
      .win_tick (win_tick),
      .ack_s    (ack_s),
      .snap     (snap),
      .ratio_q  (ratio_o)
   );
endmodule

// File: tb/clk_ratio_monitor_test.sv
`timescale 1ns/1ps
module clk_ratio_monitor_test;
   localparam int unsigned INT_W  = 2;
   localparam int unsigned FRAC_W = 6;
   localparam int unsigned RES_W  = INT_W + FRAC_W;
   localparam int unsigned WIN    = 1 << FRAC_W;
   localparam real         REF_T  = 10.0;
   localparam int unsigned SAT    = (1 << RES_W) - 1;

   logic             ref_clk = 1'b0;
   logic             mon_clk = 1'b0;
   logic             ref_rst_n = 1'b0;
   logic             mon_rst_n = 1'b0;
   logic [RES_W-1:0] ratio_o;

   real mon_half = 5.0;
   bit  mon_run  = 1'b1;
   int  n_total  = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   clk_ratio_monitor #(.INT_W(INT_W), .FRAC_W(FRAC_W), .SYNC_STAGES(2)) uut (
      .ref_clk   (ref_clk),
      .ref_rst_n (ref_rst_n),
      .mon_clk   (mon_clk),
      .mon_rst_n (mon_rst_n),
      .ratio_o   (ratio_o)
   );

   always #5 ref_clk = ~ref_clk;

   always begin
      if (mon_run) begin
         #(mon_half) mon_clk = ~mon_clk;
      end else begin
         #1;
      end
   end

   task automatic check_exact(string req, int unsigned exp);
      n_total++;
      if (ratio_o != RES_W'(exp)) begin
         n_fail++;
         $display("FAIL %s: ratio actual=%0d expected=%0d", req, ratio_o, exp);
      end
   endtask

   task automatic check_near(string req, real exp);
      real diff;
      diff = real'(ratio_o) - exp;
      if (diff < 0.0) diff = -diff;
      n_total++;
      if (diff > 1.0) begin
         n_fail++;
         $display("FAIL %s: ratio actual=%0d expected=%0.2f (+/-1)", req, ratio_o, exp);
      end
   endtask

   task automatic wait_windows(int n);
      repeat (n * WIN) @(negedge ref_clk);
   endtask

   task automatic set_period(real mon_t);
      mon_half = mon_t / 2.0;
      wait_windows(5);
   endtask

   // R2: zero in reset and through the discarded first window
   task automatic test_reset();
      repeat (4) @(negedge ref_clk);
      check_exact("R2 in reset", 0);
      ref_rst_n = 1'b1;
      mon_rst_n = 1'b1;
      repeat (WIN + 40) @(negedge ref_clk);
      check_exact("R2 before second boundary", 0);
   endtask

   // R1/R8: equal frequencies, repeated windows
   task automatic test_equal();
      set_period(10.0);
      for (int k = 0; k < 3; k++) begin
         check_near("R1 R8 equal clocks", real'(WIN));
         wait_windows(1);
      end
   endtask

   // R3: ratio scales with frequency
   task automatic test_scaled(real mon_t, string req);
      set_period(mon_t);
      for (int k = 0; k < 2; k++) begin
         check_near(req, real'(WIN) * REF_T / mon_t);
         wait_windows(1);
      end
   endtask

   // R7: at most one change per window
   task automatic test_hold();
      int changes;
      logic [RES_W-1:0] prev;
      set_period(13.0);
      changes = 0;
      prev = ratio_o;
      for (int k = 0; k < 2 * WIN; k++) begin
         @(negedge ref_clk);
         if (ratio_o != prev) changes++;
         prev = ratio_o;
      end
      n_total++;
      if (changes > 2) begin
         n_fail++;
         $display("FAIL R7: updates in two windows actual=%0d expected<=2", changes);
      end
   endtask

   // R4: saturation when the count overruns the width
   task automatic test_saturate();
      set_period(2.0);
      check_exact("R4 saturate", SAT);
      wait_windows(1);
      check_exact("R4 saturate held", SAT);
   endtask

   // R5/R6: stopped clock reads zero, then recovery
   task automatic test_stop_restart();
      set_period(10.0);
      mon_run = 1'b0;
      wait_windows(4);
      check_exact("R5 stopped clock", 0);
      wait_windows(2);
      check_exact("R5 stays zero", 0);
      mon_run = 1'b1;
      wait_windows(5);
      check_near("R6 after restart", real'(WIN));
      wait_windows(1);
      check_near("R6 after restart next", real'(WIN));
   endtask

   initial begin
      test_reset();
      test_equal();
      test_scaled(20.0, "R3 half speed");
      test_scaled(13.0, "R3 slower");
      test_scaled(7.0,  "R3 faster");
      test_hold();
      test_saturate();
      test_stop_restart();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         n_total++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end
endmodule